// File: doc/BRIEF.md
# Byte-Addressed GPIO Register Block

This block gives a processor byte-wide access to a bank of general-purpose pins. Each pin owns one control byte at its own offset. The byte carries the value the pin drives, the pin's current input value and a drive-enable flag. A read-only window at the low offsets packs the input bits of all pins into bytes, so software can sample many pins in a single read.

External pin inputs are compared against their previous value every clock. A change updates only that pin's input bit. Two pins are wired to interrupt lines with fixed sense. One line is active-low and level style. The other line follows its pin high. A rising edge on the non-maskable request input fires a one-cycle pulse on that second line.

When a control byte is written with the drive enable set, the input bit loops back from the written output bit. When a pin changes while it is being driven, a sticky conflict flag is set.

Top module: `gpio_byte_ctrl`

## Requirements
- R1: A control byte uses bit 0 for output value, bit 1 for input value and bit 2 for drive enable. Bits 7..3 are stored as written and read back.
- R2: A write to a control byte discards the written bit 1. If the written bit 2 is 1, the stored input bit becomes the written bit 0. Otherwise the input bit keeps its previous value.
- R3: Reads return data one clock after the request and hold it until the next read. Offsets 44 to 63 read as zero, and writes to them change nothing.
- R4: Offsets 0 to 7 are the level window. Byte k, bit j holds the input bit of pin 8k+j, and it is zero when that pin does not exist. Writes to offsets 0 to 7 change no state.
- R5: Offset 8+n is the control byte of pin n, for n from 0 to 35. When an external input differs from its value in the previous clock, only that pin's input bit takes the new value, at the next edge. Pins that do not change are unaffected.
- R6: Interrupt output 1 goes high one clock after pin 1's input changes to low. It goes low one clock after that input changes to high.
- R7: Interrupt output 9 takes the new value of pin 9's input one clock after that input changes.
- R8: A rising edge on the request input drives interrupt output 9 high for exactly one clock. Pin 9's input bit is then left at 0. Holding the request high gives no further pulse.
- R9: After synchronous reset, all control bytes read 0 except pin 1, which reads 0x02. All interrupt outputs are low, the conflict flag is low and the read data is zero.
- R10: If a pin's input changes while its drive enable is set, the conflict flag goes high at the next edge and stays high until reset. The input bit still updates.
- R11: There are ten interrupt outputs. Every output other than 1 and 9 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Byte access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 36 | External pin input levels |
| nmi_req | input | 1 | Non-maskable request; its rising edge fires a pulse |
| irq_out | output | 10 | Interrupt lines |
| drive_conflict | output | 1 | Sticky flag: a driven pin changed its input |

## Verification
The bench reads back a pin's control byte or its level window byte one cycle after a write or a pin change. A corrupted input bit, enable bit or stored upper bit therefore shows on the read data within two clocks. A wrong interrupt state machine shows on irq_out at the first negedge after the triggering edge. A pulse that lasts too long is caught one clock later. Writes to the level window and to void offsets are followed by reads of the nearby control bytes, so an aliasing decode shows up as a changed byte.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Control byte bit positions (software decodes these)
  localparam int OD_BIT = 0;
  localparam int IN_BIT = 1;
  localparam int OE_BIT = 2;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 36,
  parameter int IDX_W    = 6,
  parameter int HIGH_PIN = 1,
  parameter int EDGE_PIN = 9
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [BYTE_W-1:0]                wr_data,
  input  logic [NUM_PINS-1:0]              pin_in,
  input  logic                             force_set,
  input  logic                             force_clr,
  output logic [NUM_PINS-1:0][BYTE_W-1:0]  ctrl_q,
  output logic [NUM_PINS-1:0]              in_q,
  output logic [NUM_PINS-1:0]              chg,
  output logic                             conflict
);
  localparam logic [NUM_PINS-1:0] IN_RST = NUM_PINS'(1) << HIGH_PIN;

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] oe_vec;
  logic                unused_wbit;

  assign unused_wbit = wr_data[IN_BIT];
  assign chg = pin_in ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= IN_RST;
      conflict <= 1'b0;
    end else begin
      prev_q <= pin_in;
      if (|(chg & oe_vec)) conflict <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam bit IS_EDGE = (g == EDGE_PIN);
    logic       hit;
    logic [4:0] hi_q;
    logic       oe_r, od_r, in_r;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= '0;
        oe_r <= 1'b0;
        od_r <= 1'b0;
      end else if (hit) begin
        hi_q <= wr_data[7:3];
        oe_r <= wr_data[OE_BIT];
        od_r <= wr_data[OD_BIT];
      end
    end

    // Priority: request sequence, then pin change, then write loop-back
    always_ff @(posedge clk) begin
      if (rst)                        in_r <= IN_RST[g];
      else if (IS_EDGE && force_set)  in_r <= 1'b1;
      else if (IS_EDGE && force_clr)  in_r <= 1'b0;
      else if (chg[g])                in_r <= pin_in[g];
      else if (hit && wr_data[OE_BIT]) in_r <= wr_data[OD_BIT];
    end

    assign oe_vec[g] = oe_r;
    assign in_q[g]   = in_r;
    assign ctrl_q[g] = {hi_q, oe_r, in_r, od_r};

    // R2: driven write loops output bit back into input bit
    p_loopback_r2: assert property (@(posedge clk) disable iff (rst)
      (hit && wr_data[OE_BIT] && !chg[g] && !(IS_EDGE && (force_set || force_clr)))
      |=> (in_r == $past(wr_data[OD_BIT])));

    // R5: a pin change lands in the input bit at the next edge
    p_pin_follow_r5: assert property (@(posedge clk) disable iff (rst)
      (chg[g] && !(IS_EDGE && (force_set || force_clr)))
      |=> (in_r == $past(pin_in[g])));
  end

  // R10: conflict flag is sticky
  p_conflict_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int NUM_IRQ  = 10,
  parameter int LVL_PIN  = 1,
  parameter int EDGE_PIN = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl_pin,
  input  logic               lvl_chg,
  input  logic               edge_pin,
  input  logic               edge_chg,
  input  logic               nmi_req,
  output logic [NUM_IRQ-1:0] irq,
  output logic               force_set,
  output logic               force_clr
);
  logic nmi_prev, nmi_ph, lvl_q, edge_q, nmi_rise;

  assign nmi_rise  = nmi_req & ~nmi_prev;
  assign force_set = nmi_rise;
  assign force_clr = nmi_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b0;
      nmi_ph   <= 1'b0;
      lvl_q    <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      nmi_prev <= nmi_req;
      nmi_ph   <= nmi_rise;
      if (lvl_chg) lvl_q <= ~lvl_pin;
      if (nmi_rise)      edge_q <= 1'b1;
      else if (nmi_ph)   edge_q <= 1'b0;
      else if (edge_chg) edge_q <= edge_pin;
    end
  end

  always_comb begin
    irq           = '0;
    irq[LVL_PIN]  = lvl_q;
    irq[EDGE_PIN] = edge_q;
  end

  // R6: active-low level line
  p_lvl_low_r6: assert property (@(posedge clk) disable iff (rst)
    lvl_chg |=> (irq[LVL_PIN] == !$past(lvl_pin)));

  // R7: edge line follows its pin outside a request pulse
  p_edge_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (edge_chg && !nmi_rise && !nmi_ph) |=> (irq[EDGE_PIN] == $past(edge_pin)));

  // R8: request pulse is exactly one clock wide
  p_nmi_high_r8: assert property (@(posedge clk) disable iff (rst)
    nmi_rise |=> irq[EDGE_PIN]);
  p_nmi_drop_r8: assert property (@(posedge clk) disable iff (rst)
    nmi_ph |=> !irq[EDGE_PIN]);
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 36,
  parameter int ADDR_W    = 6,
  parameter int LVL_BYTES = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_PINS-1:0][BYTE_W-1:0] ctrl_q,
  input  logic [NUM_PINS-1:0]             in_q,
  output logic [BYTE_W-1:0]               rdata
);
  localparam int LB_W  = $clog2(LVL_BYTES);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [LVL_BYTES*BYTE_W-1:0] lvl_flat;
  logic [ADDR_W-1:0]           rel;
  logic [BYTE_W-1:0]           rd_next;

  for (genvar b = 0; b < LVL_BYTES*BYTE_W; b++) begin : g_lvl
    if (b < NUM_PINS) begin : g_live
      assign lvl_flat[b] = in_q[b];
    end else begin : g_void
      assign lvl_flat[b] = 1'b0;
    end
  end

  assign rel = addr - ADDR_W'(LVL_BYTES);

  always_comb begin
    rd_next = '0;
    if (addr < ADDR_W'(LVL_BYTES))
      rd_next = lvl_flat[addr[LB_W-1:0]*BYTE_W +: BYTE_W];
    else if (rel < ADDR_W'(NUM_PINS))
      rd_next = ctrl_q[rel[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R3: void offsets read zero; data holds between reads
  p_rd_void_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(LVL_BYTES + NUM_PINS)) |=> (rdata == '0));
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/gpio_byte_ctrl.sv
module gpio_byte_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 36,
  parameter int ADDR_W    = 6,
  parameter int LVL_BYTES = 8,
  parameter int NUM_IRQ   = 10,
  parameter int LVL_PIN   = 1,
  parameter int EDGE_PIN  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                nmi_req,
  output logic [NUM_IRQ-1:0]  irq_out,
  output logic                drive_conflict
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [ADDR_W-1:0]               rel;
  logic                            wr_en, force_set, force_clr;
  logic [NUM_PINS-1:0][BYTE_W-1:0] ctrl_q;
  logic [NUM_PINS-1:0]             in_q, chg;

  assign rel   = bus_addr - ADDR_W'(LVL_BYTES);
  assign wr_en = bus_sel && bus_we && (bus_addr >= ADDR_W'(LVL_BYTES))
                 && (rel < ADDR_W'(NUM_PINS));

  gpio_pin_bank #(
    .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .HIGH_PIN(LVL_PIN), .EDGE_PIN(EDGE_PIN)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(rel[IDX_W-1:0]),
    .wr_data(bus_wdata), .pin_in(pin_in), .force_set(force_set),
    .force_clr(force_clr), .ctrl_q(ctrl_q), .in_q(in_q), .chg(chg),
    .conflict(drive_conflict)
  );

  gpio_irq_map #(
    .NUM_IRQ(NUM_IRQ), .LVL_PIN(LVL_PIN), .EDGE_PIN(EDGE_PIN)
  ) u_irq (
    .clk(clk), .rst(rst), .lvl_pin(pin_in[LVL_PIN]), .lvl_chg(chg[LVL_PIN]),
    .edge_pin(pin_in[EDGE_PIN]), .edge_chg(chg[EDGE_PIN]), .nmi_req(nmi_req),
    .irq(irq_out), .force_set(force_set), .force_clr(force_clr)
  );

  gpio_rd_port #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .LVL_BYTES(LVL_BYTES)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_sel && !bus_we), .addr(bus_addr),
    .ctrl_q(ctrl_q), .in_q(in_q), .rdata(bus_rdata)
  );
endmodule

// File: tb/sim_gpio_byte_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_byte_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [35:0] pin_in = 36'h2;
  logic        nmi_req = 1'b0;
  logic [9:0]  irq_out;
  logic        drive_conflict;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_byte_ctrl u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .nmi_req(nmi_req), .irq_out(irq_out),
    .drive_conflict(drive_conflict)
  );

  // entry: {is_read, addr[5:0], data[7:0], expected[7:0], tag number}
  localparam int NV = 21;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 6'd8,  8'h05, 8'h00, 8'd2},   // R2 driven write
    {1'b1, 6'd8,  8'h00, 8'h07, 8'd2},   // R2 loop-back od->in
    {1'b0, 6'd8,  8'h04, 8'h00, 8'd2},
    {1'b1, 6'd8,  8'h00, 8'h04, 8'd2},   // R2 loop-back of 0
    {1'b0, 6'd8,  8'hF3, 8'h00, 8'd1},
    {1'b1, 6'd8,  8'h00, 8'hF1, 8'd1},   // R1 upper bits kept, in bit discarded
    {1'b0, 6'd9,  8'h00, 8'h00, 8'd9},
    {1'b1, 6'd9,  8'h00, 8'h02, 8'd9},   // R9 pin 1 input stays high
    {1'b0, 6'd43, 8'h0D, 8'h00, 8'd5},
    {1'b1, 6'd43, 8'h00, 8'h0F, 8'd5},   // R5 last pin byte
    {1'b0, 6'd3,  8'hFF, 8'h00, 8'd4},
    {1'b1, 6'd3,  8'h00, 8'h00, 8'd4},   // R4 level write ignored
    {1'b1, 6'd11, 8'h00, 8'h00, 8'd4},   // R4 no alias into pin 3
    {1'b1, 6'd4,  8'h00, 8'h08, 8'd4},   // R4 pin 35 -> byte 4 bit 3
    {1'b1, 6'd0,  8'h00, 8'h02, 8'd4},   // R4 pin 1 -> byte 0 bit 1
    {1'b0, 6'd24, 8'h05, 8'h00, 8'd4},
    {1'b1, 6'd2,  8'h00, 8'h01, 8'd4},   // R4 pin 16 -> byte 2 bit 0
    {1'b0, 6'd44, 8'hFF, 8'h00, 8'd3},
    {1'b1, 6'd44, 8'h00, 8'h00, 8'd3},   // R3 void offset
    {1'b1, 6'd63, 8'h00, 8'h00, 8'd3},   // R3 top offset
    {1'b1, 6'd47, 8'h00, 8'h00, 8'd3}    // R3 inside region, past pins
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 rdata", 32'(bus_rdata), 32'h0);
    chk("R9 irq", 32'(irq_out), 32'h0);
    chk("R9 conflict", 32'(drive_conflict), 32'h0);
    bus_rd(6'd9, d);  chk("R9 pin1 byte", 32'(d), 32'h02);
    bus_rd(6'd8, d);  chk("R9 pin0 byte", 32'(d), 32'h00);
    chk("R3 hold", 32'(bus_rdata), 32'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][30]) begin
        bus_rd(VEC[i][29:24], d);
        chk($sformatf("R%0d vec %0d", VEC[i][7:0], i), 32'(d), 32'(VEC[i][15:8]));
      end else begin
        bus_wr(VEC[i][29:24], VEC[i][23:16]);
      end
    end

    // R6 / R5: pin 1 goes low
    @(negedge clk); pin_in[1] = 1'b0;
    @(negedge clk); chk("R6 irq1 asserted", 32'(irq_out[1]), 32'h1);
    bus_rd(6'd9, d);  chk("R5 pin1 in bit", 32'(d), 32'h00);
    bus_rd(6'd8, d);  chk("R5 pin0 untouched", 32'(d), 32'hF1);
    bus_rd(6'd0, d);  chk("R4 level after change", 32'(d), 32'h00);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk); chk("R6 irq1 released", 32'(irq_out[1]), 32'h0);

    // R7 / R11
    @(negedge clk); pin_in[9] = 1'b1;
    @(negedge clk); chk("R7 R11 irq vector", 32'(irq_out), 32'h200);
    @(negedge clk); pin_in[9] = 1'b0;
    @(negedge clk); chk("R7 irq9 low", 32'(irq_out[9]), 32'h0);

    // R8: request pulse
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); chk("R8 pulse high", 32'(irq_out[9]), 32'h1);
    @(negedge clk); chk("R8 pulse ends", 32'(irq_out[9]), 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 no repeat", 32'(irq_out[9]), 32'h0);
    nmi_req = 1'b0;
    bus_rd(6'd17, d); chk("R8 pin9 in bit", 32'(d), 32'h00);

    // R10: driven pin 35 changes
    chk("R10 clear before", 32'(drive_conflict), 32'h0);
    @(negedge clk); pin_in[35] = 1'b1;
    @(negedge clk); chk("R10 flag set", 32'(drive_conflict), 32'h1);
    pin_in[35] = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd(6'd43, d); chk("R10 in bit updated", 32'(d), 32'h0D);
    chk("R10 flag sticky", 32'(drive_conflict), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule